// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block collects interrupt requests from twelve fixed sources and gives the processor one request level. That level is the highest level among the sources that are currently requesting. Each source has its own control byte. The byte holds an enable bit, a 3-bit priority level, a bit that selects who supplies the vector, and a pending latch that software clears by writing a 1. A master enable in a general control byte gates every source at once.

When the processor runs an acknowledge cycle, it pulses `iack`. The block then returns a vector equal to a programmable base plus the index of the winning source. The source indices are fixed:

| Index | Source |
|---|---|
| 0 | power fail |
| 1 | bus error |
| 2 | abort switch |
| 3 | serial |
| 4 | ethernet |
| 5 | SCSI |
| 6 | DMA |
| 7 | printer |
| 8 | timer A |
| 9 | timer B |
| 10 | software A |
| 11 | software B |

For the serial source, the block supplies the vector only when that source's vector-supply bit is set. Otherwise the block raises a "no vector" flag so that the peripheral can drive the vector itself. The abort source's byte also reads back the live state of the abort switch.

Register map:

| Address | Register |
|---|---|
| 0 to 11 | slot control byte of the source with that index |
| 12 | general control byte |
| 13 | vector base |
| any other | reads as zero |

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every pending latch, enable and level is 0. The master enable is 0 and the vector base reads 0x40. `irq_level`, `vec_valid` and `no_vec` are 0, and addresses 14 and 15 read 0x00.
- R2: A pending latch is set only by a low-to-high change of its source request, sampled at the clock. A request that stays high does not set the latch again after it has been cleared.
- R3: Writing a slot byte with bit 7 at 1 clears that slot's pending latch. A write with bit 7 at 0 leaves the latch unchanged. If a rising request edge arrives in the same cycle as the clear, the latch stays set.
- R4: A slot byte has this layout: bit 7 reads back the pending state, bit 4 is the vector-supply bit, bit 3 is the enable, and bits 2:0 are the level. Bits 6 and 5 read 0, except bit 6 of the abort slot (index 2).
- R5: Bit 4 of the general control byte (address 12) is the master enable. While it is 0, `irq_level` is 0 whatever the pending state.
- R6: `irq_level` is the highest level among the sources that are pending, enabled, and have a nonzero level, while the master enable is 1. A source with level 0 never requests.
- R7: When several requesting sources share the highest level, the one with the lowest index wins the vector.
- R8: If the clock edge sees `iack` high while a source is requesting, then in the following cycle `vec_out` equals base plus winner index and `vec_valid` is 1 for that one cycle. With no source requesting, both flags stay 0.
- R9: The vector base is written at address 13. Every later vector uses the new base, and the base reads back unchanged.
- R10: Bit 6 of the abort slot byte (address 2) reads back the `abort_sw` input combinationally.
- R11: If the winner is the serial source (index 3) and its vector-supply bit (bit 4) is 0, the acknowledge sets `no_vec` for one cycle and leaves `vec_valid` at 0. If the bit is 1, the block supplies base + 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 12 | Request lines of the sources, bit i is source i |
| abort_sw | input | 1 | Live state of the abort switch |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| iack | input | 1 | Interrupt-acknowledge strobe |
| irq_level | output | 3 | Highest active request level, 0 means none |
| vec_out | output | 8 | Vector captured at the last acknowledge |
| vec_valid | output | 1 | One-cycle flag: `vec_out` holds a block-supplied vector |
| no_vec | output | 1 | One-cycle flag: the peripheral must supply the vector |

## Verification
Requests and writes take effect at the clock edge that samples them. Pending state, read data and `irq_level` therefore change one edge after the stimulus. The vector flags appear one edge after the edge that samples `iack`, and last exactly one cycle. The bench drives inputs on falling edges. A behavioural model advances on each rising edge, and the outputs are compared with it 2 ns after that edge. Directed checks sample at the next falling edge, after every register on the path has updated.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int SRC_COUNT   = 12;
  localparam int LEVEL_W     = 3;
  localparam int BYTE_W      = 8;
  localparam int REG_ADDR_W  = 4;
  localparam int ABORT_IDX   = 2;
  localparam int SERIAL_IDX  = 3;
  localparam int GCTL_ADDR   = 12;
  localparam int VBASE_ADDR  = 13;
  localparam logic [BYTE_W-1:0] VBASE_RESET = 8'h40;

  // bit positions inside a slot control byte
  localparam int B_CLR = 7;
  localparam int B_SW  = 6;
  localparam int B_VS  = 4;
  localparam int B_EN  = 3;
  localparam int B_MEN = 4;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr_sel,
  input  logic             clr_bit,
  input  logic             vs_bit,
  input  logic             en_bit,
  input  logic [LVL_W-1:0] lvl_bits,
  output logic             pend,
  output logic             en,
  output logic             vsup,
  output logic [LVL_W-1:0] lvl
);
  logic             prev_q, pend_q, en_q, vs_q;
  logic [LVL_W-1:0] lvl_q;
  logic             pend_d, rise, clr;

  always_comb begin
    rise   = req & ~prev_q;
    clr    = wr_sel & clr_bit;
    pend_d = rise | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= req;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vs_q  <= 1'b0;
      lvl_q <= '0;
    end else if (wr_sel) begin
      en_q  <= en_bit;
      vs_q  <= vs_bit;
      lvl_q <= lvl_bits;
    end
  end

  assign pend = pend_q;
  assign en   = en_q;
  assign vsup = vs_q;
  assign lvl  = lvl_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N     = 12,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            act,
  input  logic [N-1:0][LVL_W-1:0] lvl,
  output logic [LVL_W-1:0]        best_lvl,
  output logic [IDX_W-1:0]        best_idx
);
  // strict compare keeps the lowest index on equal levels
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && (lvl[i] > best_lvl)) begin
        best_lvl = lvl[i];
        best_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit #(
  parameter int VEC_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack,
  input  logic             any,
  input  logic             ext_src,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [VEC_W-1:0] base,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid,
  output logic             no_vec
);
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vv_q, vv_d, nv_q, nv_d, vec_ce;

  always_comb begin
    vec_ce = iack;
    vv_d   = iack & any & ~ext_src;
    nv_d   = iack & any & ext_src;
    vec_d  = vv_d ? (base + {{(VEC_W-IDX_W){1'b0}}, win_idx}) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q <= 1'b0;
      nv_q <= 1'b0;
    end else begin
      vv_q <= vv_d;
      nv_q <= nv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_ce) vec_q <= vec_d;
  end

  assign vec_out   = vec_q;
  assign vec_valid = vv_q;
  assign no_vec    = nv_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int LVL_W   = LEVEL_W,
  parameter int DATA_W  = BYTE_W,
  parameter int ADDR_W  = REG_ADDR_W,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               abort_sw,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               iack,
  output logic [LVL_W-1:0]   irq_level,
  output logic [DATA_W-1:0]  vec_out,
  output logic               vec_valid,
  output logic               no_vec
);
  logic [1:0]                   rst_sync;
  logic                         rst_int;
  logic [NUM_SRC-1:0]           pend, en, vsup, act;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic                         men_q;
  logic [DATA_W-1:0]            base_q;
  logic [IDX_W-1:0]             win_idx;
  logic                         any, ext_src;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    irq_src_slot #(.LVL_W(LVL_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_int),
      .req      (src_req[i]),
      .wr_sel   (wr_en && (wr_addr == ADDR_W'(i))),
      .clr_bit  (wr_data[B_CLR]),
      .vs_bit   (wr_data[B_VS]),
      .en_bit   (wr_data[B_EN]),
      .lvl_bits (wr_data[LVL_W-1:0]),
      .pend     (pend[i]),
      .en       (en[i]),
      .vsup     (vsup[i]),
      .lvl      (lvl[i])
    );
    assign act[i] = pend[i] & en[i] & men_q & (|lvl[i]);
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      men_q  <= 1'b0;
      base_q <= VBASE_RESET;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(GCTL_ADDR))  men_q  <= wr_data[B_MEN];
      if (wr_addr == ADDR_W'(VBASE_ADDR)) base_q <= wr_data;
    end
  end

  irq_arbiter #(.N(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .act      (act),
    .lvl      (lvl),
    .best_lvl (irq_level),
    .best_idx (win_idx)
  );

  always_comb begin
    any     = |act;
    ext_src = (win_idx == IDX_W'(SERIAL_IDX)) && !vsup[SERIAL_IDX];
  end

  irq_vec_unit #(.VEC_W(DATA_W), .IDX_W(IDX_W)) u_vec (
    .clk       (clk),
    .rst_n     (rst_int),
    .iack      (iack),
    .any       (any),
    .ext_src   (ext_src),
    .win_idx   (win_idx),
    .base      (base_q),
    .vec_out   (vec_out),
    .vec_valid (vec_valid),
    .no_vec    (no_vec)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        rd_data[B_CLR]       = pend[i];
        rd_data[B_SW]        = (i == ABORT_IDX) ? abort_sw : 1'b0;
        rd_data[B_VS]        = vsup[i];
        rd_data[B_EN]        = en[i];
        rd_data[LVL_W-1:0]   = lvl[i];
      end
    end
    if (rd_addr == ADDR_W'(GCTL_ADDR))  rd_data[B_MEN] = men_q;
    if (rd_addr == ADDR_W'(VBASE_ADDR)) rd_data = base_q;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N      = 12,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      src_req,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              clr_bit,
  input logic              iack,
  input logic [LVL_W-1:0]  irq_level,
  input logic              vec_valid,
  input logic              no_vec,
  input logic              men,
  input logic [N-1:0]      pend
);
  // R5
  men_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !men |-> (irq_level == '0));

  // R6
  level_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (men && (|pend)));

  // R8
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid || no_vec) |-> $past(iack));

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && no_vec));

  for (genvar i = 0; i < N; i++) begin : g_src
    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_W'(i)) && clr_bit && !src_req[i]) |=> !pend[i]);
    // R2
    set_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> $past(src_req[i]));
  end
endmodule

bind vec_irq_ctrl irq_ctrl_chk #(.N(NUM_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int),
  .src_req   (src_req),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .clr_bit   (wr_data[7]),
  .iack      (iack),
  .irq_level (irq_level),
  .vec_valid (vec_valid),
  .no_vec    (no_vec),
  .men       (men_q),
  .pend      (pend)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic        clk, rst_n;
  logic [11:0] src_req;
  logic        abort_sw, wr_en, iack;
  logic [3:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data, vec_out;
  logic [2:0]  irq_level;
  logic        vec_valid, no_vec;

  int n_run = 0, n_fail = 0;
  bit checking = 0, finished = 0;

  // model state
  bit m_pend[12], m_en[12], m_vs[12], m_prev[12];
  int m_lvl[12];
  bit m_men;
  int m_base;
  bit e_vv, e_nv;
  int e_vec;

  vec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .abort_sw(abort_sw),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .iack(iack),
    .irq_level(irq_level), .vec_out(vec_out), .vec_valid(vec_valid), .no_vec(no_vec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int model_level(output int idx);
    int best = 0;
    idx = 0;
    for (int i = 0; i < 12; i++)
      if (m_pend[i] && m_en[i] && m_men && m_lvl[i] > best) begin
        best = m_lvl[i];
        idx = i;
      end
    return best;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) begin
        m_pend[i] = 0; m_en[i] = 0; m_vs[i] = 0; m_prev[i] = 0; m_lvl[i] = 0;
      end
      m_men = 0; m_base = 8'h40; e_vv = 0; e_nv = 0; e_vec = 0;
    end else begin
      int w, lv;
      bit clr[12];
      lv = model_level(w);
      e_vv = 0; e_nv = 0;
      if (iack && lv > 0) begin
        if (w == 3 && !m_vs[3]) e_nv = 1;
        else begin e_vv = 1; e_vec = (m_base + w) & 8'hFF; end
      end
      for (int i = 0; i < 12; i++) clr[i] = 0;
      if (wr_en) begin
        if (wr_addr < 12) begin
          m_en[wr_addr] = wr_data[3];
          m_vs[wr_addr] = wr_data[4];
          m_lvl[wr_addr] = wr_data[2:0];
          clr[wr_addr] = wr_data[7];
        end else if (wr_addr == 12) m_men = wr_data[4];
        else if (wr_addr == 13) m_base = wr_data;
      end
      for (int i = 0; i < 12; i++) begin
        m_pend[i] = (src_req[i] && !m_prev[i]) || (m_pend[i] && !clr[i]);
        m_prev[i] = src_req[i];
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp, string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (checking) begin
      int w, lv;
      lv = model_level(w);
      check(irq_level == lv, "R6", irq_level, lv, "irq_level vs model");
      check(vec_valid == e_vv, "R8", vec_valid, e_vv, "vec_valid vs model");
      check(no_vec == e_nv, "R11", no_vec, e_nv, "no_vec vs model");
      if (e_vv) check(vec_out == e_vec, "R8", vec_out, e_vec, "vec_out vs model");
    end
  end

  task automatic write_reg(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[3:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(int i);
    @(negedge clk);
    src_req[i] = 1'b1;
    @(negedge clk);
    src_req[i] = 1'b0;
  endtask

  task automatic read_check(int a, int exp, string req);
    @(negedge clk);
    rd_addr = a[3:0];
    #1;
    check(rd_data == exp[7:0], req, rd_data, exp, $sformatf("read addr %0d", a));
  endtask

  task automatic level_check(int exp, string req);
    @(negedge clk);
    #1;
    check(irq_level == exp[2:0], req, irq_level, exp, "irq_level");
  endtask

  task automatic ack_check(bit vv, bit nv, int vec, string req);
    @(negedge clk);
    iack = 1'b1;
    @(negedge clk);
    iack = 1'b0;
    #1;
    check(vec_valid == vv, req, vec_valid, vv, "vec_valid after ack");
    check(no_vec == nv, req, no_vec, nv, "no_vec after ack");
    if (vv) check(vec_out == vec[7:0], req, vec_out, vec, "vec_out after ack");
    @(negedge clk);
    #1;
    check(!vec_valid && !no_vec, req, {vec_valid, no_vec}, 0, "flags one cycle only");
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src_req = '0; abort_sw = 0; wr_en = 0; wr_addr = '0;
    wr_data = '0; rd_addr = '0; iack = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    checking = 1;

    // R1 reset state
    read_check(0, 8'h00, "R1");
    read_check(12, 8'h00, "R1");
    read_check(13, 8'h40, "R1");
    read_check(15, 8'h00, "R1");
    level_check(0, "R1");
    check(!vec_valid && !no_vec, "R1", {vec_valid, no_vec}, 0, "flags at reset");

    // source 4 at level 3, master enable off then on
    write_reg(4, 8'h0B);
    pulse(4);
    level_check(0, "R5");
    read_check(4, 8'h8B, "R4");
    write_reg(12, 8'h10);
    read_check(12, 8'h10, "R5");
    level_check(3, "R6");
    ack_check(1, 0, 8'h44, "R8");

    // higher level source 8
    write_reg(8, 8'h0D);
    pulse(8);
    level_check(5, "R6");
    ack_check(1, 0, 8'h48, "R6");

    // tie at level 5: source 1 beats source 8
    write_reg(1, 8'h0D);
    pulse(1);
    ack_check(1, 0, 8'h41, "R7");

    // write-1-to-clear and write-0 keep
    write_reg(1, 8'h8D);
    read_check(1, 8'h0D, "R3");
    ack_check(1, 0, 8'h48, "R3");
    write_reg(8, 8'h0D);
    read_check(8, 8'h8D, "R3");

    // clear on source 4 in the same cycle as a new rising edge
    @(negedge clk);
    wr_en = 1; wr_addr = 4; wr_data = 8'h8B; src_req[4] = 1'b1;
    @(negedge clk);
    wr_en = 0;
    read_check(4, 8'h8B, "R3");
    // request held high: clearing sticks
    write_reg(4, 8'h8B);
    repeat (2) @(negedge clk);
    read_check(4, 8'h0B, "R2");
    src_req[4] = 1'b0;

    // new vector base
    write_reg(13, 8'h80);
    read_check(13, 8'h80, "R9");
    ack_check(1, 0, 8'h88, "R9");

    // abort switch live read-back
    abort_sw = 1;
    read_check(2, 8'h40, "R10");
    abort_sw = 0;
    read_check(2, 8'h00, "R10");

    // serial source at level 7, vector-supply bit clear then set
    write_reg(3, 8'h0F);
    pulse(3);
    level_check(7, "R6");
    read_check(3, 8'h8F, "R4");
    ack_check(0, 1, 0, "R11");
    write_reg(3, 8'h1F);
    read_check(3, 8'h9F, "R11");
    ack_check(1, 0, 8'h83, "R11");

    // a level-0 source never requests; ack with nothing active
    write_reg(3, 8'h9F);
    write_reg(8, 8'h8D);
    write_reg(10, 8'h08);
    pulse(10);
    read_check(10, 8'h88, "R6");
    level_check(0, "R6");
    ack_check(0, 0, 0, "R8");

    // master enable masks a pending source
    pulse(8);
    level_check(5, "R6");
    write_reg(12, 8'h00);
    level_check(0, "R5");
    read_check(8, 8'h8D, "R5");

    repeat (3) @(negedge clk);
    checking = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule